// File: doc/BRIEF.md
# LPC Host Cycle Engine

This block is a host-side controller for the Low Pin Count bus. Software sets up a transaction through a small register bus. It writes a command word (direction, cycle type, address mode), a byte count, a start address and, for writes, the outgoing bytes, which collect in a transmit queue. Writing the start bit then lets the engine run the whole multi-byte transaction by itself. For each byte the engine runs one complete I/O cycle on a 4-bit nibble bus with a separate frame strobe: start, type/direction, address, data, turnaround, sync, and a final turnaround.

Bytes returned by read cycles collect in a receive queue, and software drains that queue through a data register. At the end of a transaction the engine sets a sticky interrupt flag, which software clears by writing 1 to it. A status word reports whether the engine is idle and whether the last transaction finished cleanly. A peripheral can stretch a cycle with wait-state sync codes or end it with an error code. If the peripheral stays silent for longer than a programmable number of clocks, the engine aborts the bus.

The nibble bus is split into an output value, an output enable and an input value, so that a tri-state pad can sit outside the block. The current cycle phase is also driven out as a 4-bit code.

Top module: `lpc_host_engine`

## Requirements
- R1: Register offsets are: start 0x00, op status 0x04, irq status 0x08, length 0x10, command 0x14, address 0x20, write data 0x24, read data 0x28, timeout 0x58. Op status bit 0 reads 1 while the engine is idle. Op status bit 1 reads 1 after a transaction that completed every byte. After reset, op status reads 0x1, `irq` is 0, `lpc_frame_n` is 1 and `lpc_nib_oe` is 0.
- R2: Each byte cycle starts with one clock in which `lpc_frame_n` is low and the bus is driven to 0000. `lpc_frame_n` is low in no other clock of a normal cycle. The next clock carries the type nibble, 0000 for a read and 0010 for a write, selected by command bit 0 (1 = write). Four address nibbles follow, most significant first.
- R3: A write cycle sends its data byte as two nibbles, low nibble first. It then drives 1111 for one clock and floats the bus (`lpc_nib_oe` = 0) for one clock.
- R4: In sync, 0000 means ready, and 0101 or 0110 are wait codes that cause the sync to be sampled again. A read cycle floats the bus from its turnaround through sync, takes two data nibbles (low first) into the receive queue, and then floats the bus for two more turnaround clocks.
- R5: The length register sets how many byte cycles run. When command bit 3 is 1, every byte uses the programmed address. When bit 3 is 0, the address goes up by 1 for each byte.
- R6: Each write to offset 0x24 queues its low byte, and write cycles send the queued bytes in order. Each read of offset 0x28 returns the next received byte in order. The receive queue is emptied when a transaction starts.
- R7: Irq status bit 1 and the `irq` output are set when a transaction ends and stay set until software writes 1 to bit 1 of offset 0x08.
- R8: A sync code of 1010 ends the transaction. No further bytes run, op status bit 1 stays 0, the interrupt is set and the engine returns to idle on the next clock.
- R9: Consecutive sync nibbles that are neither ready, wait nor error are counted, and a wait code resets the count. When the count reaches the timeout register value, the engine enters abort. In abort it drives 1111 with `lpc_frame_n` low for 4 clocks, then returns to idle with the interrupt set and bit 1 clear.
- R10: `cyc_phase` reports the phase as 0 idle, 1 start, 2 type/direction, 3 address, 5 write data, 6 host turnaround, 7 sync, 8 read data, 9 peripheral turnaround, 10 abort. Code 4 is kept for a memory-size phase that I/O cycles never enter.
- R11: A start with command bits 2:1 not equal to 00, or with length 0, runs no bus cycle but sets the interrupt and leaves bit 1 clear. A start written while the engine is busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; read data appears the next cycle |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Sticky end-of-transaction flag |
| lpc_frame_n | output | 1 | Frame strobe, active low |
| lpc_nib_out | output | 4 | Nibble driven onto the bus |
| lpc_nib_oe | output | 1 | Bus drive enable |
| lpc_nib_in | input | 4 | Nibble sampled from the bus |
| cyc_phase | output | 4 | Encoded current phase |

## Verification
Some properties are checked by assertions on every cycle: the frame strobe is low only in start or abort, the bus floats whenever the peripheral owns it, abort can only follow sync, an error code drops straight to idle, the interrupt flag stays set until it is cleared, and a busy engine never reports finished. Other behaviour can only be shown by the bench's scenarios with a modelled peripheral. These are the exact nibble order, addresses and data across lengths and address modes, wait-state stretching, the clock at which a timeout fires, the abort length, and the order of data in the queues.

// File: rtl/lpc_host_pkg.sv
package lpc_host_pkg;

  typedef enum logic [3:0] {
    PH_IDLE    = 4'd0,
    PH_START   = 4'd1,
    PH_TYPEDIR = 4'd2,
    PH_ADDR    = 4'd3,
    PH_MSIZE   = 4'd4,
    PH_WDATA   = 4'd5,
    PH_TARH    = 4'd6,
    PH_SYNC    = 4'd7,
    PH_RDATA   = 4'd8,
    PH_TARP    = 4'd9,
    PH_ABORT   = 4'd10
  } phase_e;

  localparam logic [7:0] OFS_GO     = 8'h00;
  localparam logic [7:0] OFS_STAT   = 8'h04;
  localparam logic [7:0] OFS_IRQ    = 8'h08;
  localparam logic [7:0] OFS_LEN    = 8'h10;
  localparam logic [7:0] OFS_CMD    = 8'h14;
  localparam logic [7:0] OFS_ADDR   = 8'h20;
  localparam logic [7:0] OFS_WDATA  = 8'h24;
  localparam logic [7:0] OFS_RDATA  = 8'h28;
  localparam logic [7:0] OFS_TMO    = 8'h58;

  localparam logic [3:0] SYNC_READY = 4'b0000;
  localparam logic [3:0] SYNC_WAITS = 4'b0101;
  localparam logic [3:0] SYNC_WAITL = 4'b0110;
  localparam logic [3:0] SYNC_ERR   = 4'b1010;

  localparam logic [3:0] NIB_START  = 4'b0000;
  localparam logic [3:0] NIB_IORD   = 4'b0000;
  localparam logic [3:0] NIB_IOWR   = 4'b0010;
  localparam logic [3:0] NIB_IDLE   = 4'b1111;

endpackage

// File: rtl/lpc_byte_fifo.sv
module lpc_byte_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          full
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == (AW+1)'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  a_r6_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);
  a_r6_push_fills: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !flush) |=> !empty);

endmodule

// File: rtl/lpc_cycle_seq.sv
module lpc_cycle_seq
  import lpc_host_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LEN_W      = 8,
  parameter int TMO_W      = 8,
  parameter int ABORT_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              cmd_wr,
  input  logic              cmd_same,
  input  logic [LEN_W-1:0]  len,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [TMO_W-1:0]  tmo,
  input  logic [7:0]        tx_data,
  input  logic              tx_empty,
  input  logic [3:0]        lad_in,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [7:0]        rx_data,
  output logic              done,
  output logic              done_ok,
  output logic [3:0]        phase,
  output logic              frame_n,
  output logic [3:0]        lad_out,
  output logic              lad_oe
);
  localparam int NIB   = ADDR_W / 4;
  localparam int SUB_W = (NIB > 2) ? $clog2(NIB) : 1;
  localparam int AB_W  = (ABORT_CLKS > 2) ? $clog2(ABORT_CLKS) : 1;

  phase_e             st, st_n;
  logic [SUB_W-1:0]   sub, sub_n;
  logic [LEN_W-1:0]   left, left_n;
  logic [ADDR_W-1:0]  addr, addr_n;
  logic [7:0]         data, data_n;
  logic [TMO_W-1:0]   tcnt, tcnt_n;
  logic [AB_W-1:0]    acnt, acnt_n;
  logic               wr_q, wr_n, same_q, same_n;
  logic               fr_c, oe_c;
  logic [3:0]         lo_c;
  logic [TMO_W:0]     tnext;

  assign tnext = {1'b0, tcnt} + 1'b1;

  always_comb begin
    st_n = st; sub_n = sub; left_n = left; addr_n = addr; data_n = data;
    tcnt_n = tcnt; acnt_n = acnt; wr_n = wr_q; same_n = same_q;
    tx_pop = 1'b0; rx_push = 1'b0; rx_data = {lad_in, data[3:0]};
    done = 1'b0; done_ok = 1'b0;
    case (st)
      PH_IDLE: if (go) begin
        st_n = PH_START; left_n = len; addr_n = base_addr;
        wr_n = cmd_wr; same_n = cmd_same; data_n = 8'h00;
        if (cmd_wr && !tx_empty) begin data_n = tx_data; tx_pop = 1'b1; end
      end
      PH_START:   st_n = PH_TYPEDIR;
      PH_TYPEDIR: begin st_n = PH_ADDR; sub_n = '0; end
      PH_ADDR: begin
        if (sub == SUB_W'(NIB-1)) begin
          sub_n = '0;
          st_n  = wr_q ? PH_WDATA : PH_TARH;
        end else sub_n = sub + 1'b1;
      end
      PH_WDATA: begin
        if (sub[0]) begin st_n = PH_TARH; sub_n = '0; end
        else sub_n = SUB_W'(1);
      end
      PH_TARH: begin
        if (sub[0]) begin st_n = PH_SYNC; sub_n = '0; tcnt_n = '0; end
        else sub_n = SUB_W'(1);
      end
      PH_SYNC: begin
        case (lad_in)
          SYNC_READY: begin st_n = wr_q ? PH_TARP : PH_RDATA; sub_n = '0; end
          SYNC_WAITS, SYNC_WAITL: tcnt_n = '0;
          SYNC_ERR: begin st_n = PH_IDLE; done = 1'b1; end
          default: begin
            if (tnext >= {1'b0, tmo}) begin st_n = PH_ABORT; acnt_n = '0; end
            else tcnt_n = tnext[TMO_W-1:0];
          end
        endcase
      end
      PH_RDATA: begin
        if (sub[0]) begin
          rx_push = 1'b1; st_n = PH_TARP; sub_n = '0;
        end else begin
          data_n[3:0] = lad_in; sub_n = SUB_W'(1);
        end
      end
      PH_TARP: begin
        if (!sub[0]) sub_n = SUB_W'(1);
        else if (left == LEN_W'(1)) begin
          st_n = PH_IDLE; sub_n = '0; done = 1'b1; done_ok = 1'b1;
        end else begin
          st_n = PH_START; sub_n = '0; left_n = left - 1'b1;
          addr_n = same_q ? addr : addr + 1'b1;
          data_n = 8'h00;
          if (wr_q && !tx_empty) begin data_n = tx_data; tx_pop = 1'b1; end
        end
      end
      PH_ABORT: begin
        if (acnt == AB_W'(ABORT_CLKS-1)) begin st_n = PH_IDLE; done = 1'b1; end
        else acnt_n = acnt + 1'b1;
      end
      default: st_n = PH_IDLE;
    endcase
  end

  always_comb begin
    fr_c = 1'b1; oe_c = 1'b0; lo_c = NIB_IDLE;
    case (st_n)
      PH_START:   begin fr_c = 1'b0; oe_c = 1'b1; lo_c = NIB_START; end
      PH_TYPEDIR: begin oe_c = 1'b1; lo_c = wr_n ? NIB_IOWR : NIB_IORD; end
      PH_ADDR:    begin oe_c = 1'b1; lo_c = addr_n[4*(NIB-1-int'(sub_n)) +: 4]; end
      PH_WDATA:   begin oe_c = 1'b1; lo_c = sub_n[0] ? data_n[7:4] : data_n[3:0]; end
      PH_TARH:    begin oe_c = !sub_n[0]; lo_c = NIB_IDLE; end
      PH_ABORT:   begin fr_c = 1'b0; oe_c = 1'b1; lo_c = NIB_IDLE; end
      default:    begin fr_c = 1'b1; oe_c = 1'b0; lo_c = NIB_IDLE; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= PH_IDLE; sub <= '0; left <= '0; addr <= '0; data <= '0;
      tcnt <= '0; acnt <= '0; wr_q <= 1'b0; same_q <= 1'b0;
      frame_n <= 1'b1; lad_out <= NIB_IDLE; lad_oe <= 1'b0;
    end else begin
      st <= st_n; sub <= sub_n; left <= left_n; addr <= addr_n; data <= data_n;
      tcnt <= tcnt_n; acnt <= acnt_n; wr_q <= wr_n; same_q <= same_n;
      frame_n <= fr_c; lad_out <= lo_c; lad_oe <= oe_c;
    end
  end

  assign phase = st;

  // R2: frame strobe low only in the start clock (or abort)
  a_r2_frame_low_only_start: assert property (@(posedge clk) disable iff (rst)
    !frame_n |-> (st == PH_START || st == PH_ABORT));
  // R4: peripheral-owned phases never see the host driving
  a_r4_float_when_peripheral: assert property (@(posedge clk) disable iff (rst)
    (st == PH_SYNC || st == PH_RDATA || st == PH_TARP) |-> !lad_oe);
  // R9: abort is only reachable from a silent sync
  a_r9_abort_after_sync: assert property (@(posedge clk) disable iff (rst)
    $rose(st == PH_ABORT) |-> $past(st) == PH_SYNC);
  // R8: error sync ends the transaction at once
  a_r8_error_to_idle: assert property (@(posedge clk) disable iff (rst)
    (st == PH_SYNC && lad_in == SYNC_ERR) |=> st == PH_IDLE);

endmodule

// File: rtl/lpc_host_engine.sv
module lpc_host_engine
  import lpc_host_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LEN_W      = 8,
  parameter int TMO_W      = 8,
  parameter int DEF_TMO    = 16,
  parameter int FIFO_DEPTH = 16,
  parameter int ABORT_CLKS = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        lpc_frame_n,
  output logic [3:0]  lpc_nib_out,
  output logic        lpc_nib_oe,
  input  logic [3:0]  lpc_nib_in,
  output logic [3:0]  cyc_phase
);
  logic [3:0]        cmd_q;
  logic [LEN_W-1:0]  len_q;
  logic [ADDR_W-1:0] addr_q;
  logic [TMO_W-1:0]  tmo_q;
  logic              fin_q, irq_q;
  logic              idle, start_req, cmd_ok, go, irq_clr;
  logic              tx_pop, tx_empty, tx_full, rx_push, rx_empty, rx_full;
  logic              done, done_ok, tx_flush;
  logic [7:0]        tx_data, rx_data, rx_dout;
  logic              unused_bits;

  assign unused_bits = ^{bus_wdata, tx_full, rx_full};

  assign idle      = (cyc_phase == PH_IDLE);
  assign start_req = bus_wr && bus_addr == OFS_GO && bus_wdata[0] && idle;
  assign cmd_ok    = (cmd_q[2:1] == 2'b00) && (len_q != '0);
  assign go        = start_req && cmd_ok;
  assign irq_clr   = bus_wr && bus_addr == OFS_IRQ && bus_wdata[1];
  assign tx_flush  = done || (start_req && !cmd_ok);

  lpc_byte_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(tx_flush),
    .push(bus_wr && bus_addr == OFS_WDATA), .din(bus_wdata[7:0]),
    .pop(tx_pop), .dout(tx_data), .empty(tx_empty), .full(tx_full));

  lpc_byte_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(go),
    .push(rx_push), .din(rx_data),
    .pop(bus_rd && bus_addr == OFS_RDATA), .dout(rx_dout),
    .empty(rx_empty), .full(rx_full));

  lpc_cycle_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .TMO_W(TMO_W),
                  .ABORT_CLKS(ABORT_CLKS)) u_seq (
    .clk(clk), .rst(rst), .go(go), .cmd_wr(cmd_q[0]), .cmd_same(cmd_q[3]),
    .len(len_q), .base_addr(addr_q), .tmo(tmo_q),
    .tx_data(tx_data), .tx_empty(tx_empty), .lad_in(lpc_nib_in),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data),
    .done(done), .done_ok(done_ok), .phase(cyc_phase),
    .frame_n(lpc_frame_n), .lad_out(lpc_nib_out), .lad_oe(lpc_nib_oe));

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0; len_q <= '0; addr_q <= '0; tmo_q <= TMO_W'(DEF_TMO);
      fin_q <= 1'b0; irq_q <= 1'b0; bus_rdata <= '0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          OFS_CMD:  cmd_q  <= bus_wdata[3:0];
          OFS_LEN:  len_q  <= bus_wdata[LEN_W-1:0];
          OFS_ADDR: addr_q <= bus_wdata[ADDR_W-1:0];
          OFS_TMO:  tmo_q  <= bus_wdata[TMO_W-1:0];
          default: ;
        endcase
      end
      if (start_req)  fin_q <= 1'b0;
      else if (done)  fin_q <= done_ok;
      if (done || (start_req && !cmd_ok)) irq_q <= 1'b1;
      else if (irq_clr)                   irq_q <= 1'b0;
      if (bus_rd) begin
        case (bus_addr)
          OFS_STAT:  bus_rdata <= {30'd0, fin_q, idle};
          OFS_IRQ:   bus_rdata <= {30'd0, irq_q, 1'b0};
          OFS_LEN:   bus_rdata <= 32'(len_q);
          OFS_CMD:   bus_rdata <= {28'd0, cmd_q};
          OFS_ADDR:  bus_rdata <= 32'(addr_q);
          OFS_TMO:   bus_rdata <= 32'(tmo_q);
          OFS_RDATA: bus_rdata <= {24'd0, rx_empty ? 8'h00 : rx_dout};
          default:   bus_rdata <= '0;
        endcase
      end
    end
  end

  assign irq = irq_q;

  // R7: flag holds until software clears it
  a_r7_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq);
  // R1: finished bit is never reported while a cycle is in flight
  a_r1_busy_not_finished: assert property (@(posedge clk) disable iff (rst)
    !idle |-> !fin_q);
  // R11: a start while busy does not restart the sequence
  a_r11_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (!idle && cyc_phase != PH_TARP && cyc_phase != PH_ABORT && cyc_phase != PH_SYNC
     && cyc_phase != PH_RDATA) |=> cyc_phase != PH_IDLE);

endmodule

// File: tb/test_lpc_host_engine.sv
`timescale 1ns/1ps
module test_lpc_host_engine;
  logic        clk = 1'b0, rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        irq, lframe_n, lad_oe;
  logic [3:0]  lad_out, lad_in = 4'hF, cyc_phase;

  lpc_host_engine i_lpc_host_engine (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .lpc_frame_n(lframe_n), .lpc_nib_out(lad_out), .lpc_nib_oe(lad_oe),
    .lpc_nib_in(lad_in), .cyc_phase(cyc_phase));

  always #2.5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  // peripheral / monitor state
  int p_t, p_wr, p_same, p_len, p_nwait, p_mode, p_badb;
  logic [15:0] p_base;
  bit mon_act = 0;
  int k = 0, b = -1, ab_cnt = 0, ab_k = -1, m_hdr = 0, m_body = 0, m_ph = 0;

  function automatic logic [7:0] wb(int t, int bi);
    return 8'(t * 11 + bi * 29 + 1);
  endfunction
  function automatic logic [7:0] rb(int bi);
    return 8'(8'h3C + bi * 37);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // peripheral model and bus monitor
  int s0, j, tp, idj, mode_b, ep;
  logic [15:0] ea;
  logic [7:0] wd, rdv;
  logic elf, eoe, chk, chl;
  logic [3:0] el;
  always @(negedge clk) begin
    lad_in = 4'hF;
    if (mon_act) begin
      if (!lframe_n && lad_oe && lad_out == 4'h0) begin b++; k = 0; end
      else k++;
      if (!lframe_n && lad_out == 4'hF) begin
        if (ab_cnt == 0) ab_k = k;
        ab_cnt++;
      end
      if (b >= 0) begin
        s0 = p_wr ? 10 : 8; j = k - s0;
        mode_b = (b == p_badb) ? p_mode : 0;
        ea = p_base + (p_same != 0 ? 16'd0 : 16'(b));
        wd = wb(p_t, b); rdv = rb(b);
        tp = p_nwait + 1 + (p_wr != 0 ? 0 : 2);
        idj = (mode_b == 1) ? p_nwait + 1 : ((b == p_len - 1) ? tp + 2 : -100);
        chk = 1; chl = 0; elf = 1; eoe = 0; el = 4'h0; ep = 0;
        if (k == 0) begin ep = 1; elf = 0; eoe = 1; chl = 1; el = 4'h0; end
        else if (k == 1) begin ep = 2; eoe = 1; chl = 1; el = p_wr != 0 ? 4'h2 : 4'h0; end
        else if (k <= 5) begin ep = 3; eoe = 1; chl = 1; el = ea[4*(5-k) +: 4]; end
        else if (p_wr != 0 && k <= 7) begin
          ep = 5; eoe = 1; chl = 1; el = (k == 6) ? wd[3:0] : wd[7:4];
        end
        else if (j == -2) begin ep = 6; eoe = 1; chl = 1; el = 4'hF; end
        else if (j == -1) ep = 6;
        else if (mode_b == 2 && ab_cnt == 0) ep = 7;
        else if (mode_b == 2) begin
          if (!lframe_n) begin ep = 10; elf = 0; eoe = 1; chl = 1; el = 4'hF; end
          else chk = 0;
        end
        else if (j <= p_nwait) ep = 7;
        else if (j == idj) ep = 0;
        else if (mode_b == 0 && p_wr == 0 && j <= p_nwait + 2) ep = 8;
        else if (mode_b == 0 && j < tp + 2) ep = 9;
        else chk = 0;
        if (chk) begin
          if (int'(cyc_phase) != ep) m_ph++;
          if (lframe_n != elf || lad_oe != eoe || (chl && lad_out != el)) begin
            if (k <= 5) m_hdr++; else m_body++;
          end
        end
        if (j >= 0) begin
          if (j < p_nwait) lad_in = j[0] ? 4'h6 : 4'h5;
          else if (j == p_nwait) lad_in = (mode_b == 0) ? 4'h0 : (mode_b == 1) ? 4'hA : 4'hF;
          else if (mode_b == 0 && p_wr == 0 && j == p_nwait + 1) lad_in = rdv[3:0];
          else if (mode_b == 0 && p_wr == 0 && j == p_nwait + 2) lad_in = rdv[7:4];
        end
      end
    end
  end

  task automatic reg_write(logic [7:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic reg_read(logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic run_tr(int t, int wr, int same, int len, int nwait, int mode, int badb,
                        logic [15:0] base, logic [1:0] ctype, bit poke, int tmo);
    logic [31:0] v;
    int n, exp_b, exp_rx;
    bit valid;
    p_t = t; p_wr = wr; p_same = same; p_len = len; p_nwait = nwait;
    p_mode = mode; p_badb = badb; p_base = base;
    valid = (ctype == 2'b00) && (len != 0);
    reg_write(8'h08, 32'h2);
    check(irq == 1'b0, "R7 irq cleared by write-one", int'(irq), 0);
    reg_write(8'h58, 32'(tmo));
    if (wr != 0) for (int i = 0; i < len; i++) reg_write(8'h24, 32'(wb(t, i)));
    reg_write(8'h14, {28'd0, same[0], ctype, wr[0]});
    reg_write(8'h10, 32'(len));
    reg_write(8'h20, 32'(base));
    b = -1; k = 0; ab_cnt = 0; ab_k = -1; m_hdr = 0; m_body = 0; m_ph = 0;
    mon_act = 1;
    reg_write(8'h00, 32'h1);
    if (poke) begin
      reg_read(8'h04, v);
      check(v[0] == 1'b0, "R1 idle bit low while busy", int'(v[0]), 0);
      reg_write(8'h00, 32'h1);
    end
    n = 0;
    while (!irq && n < 4000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    mon_act = 0;
    exp_b  = !valid ? 0 : (mode == 0 ? len : badb + 1);
    exp_rx = (!valid || wr != 0) ? 0 : (mode == 0 ? len : badb);
    check(irq == 1'b1, "R7 irq set at end", int'(irq), 1);
    check(b + 1 == exp_b, valid ? "R5 byte cycles run" : "R11 no cycle on bad command", b + 1, exp_b);
    check(m_hdr == 0, "R2 start/type/address nibbles", m_hdr, 0);
    check(m_body == 0, wr != 0 ? "R3 write data and turnaround" : "R4 read turnaround and float", m_body, 0);
    check(m_ph == 0, "R10 phase code", m_ph, 0);
    reg_read(8'h04, v);
    check(v[1:0] == {(valid && mode == 0), 1'b1},
          mode == 1 ? "R8 status after error" : mode == 2 ? "R9 status after abort" : "R1 status",
          int'(v[1:0]), int'({(valid && mode == 0), 1'b1}));
    reg_read(8'h08, v);
    check(v[1] == 1'b1, "R7 irq status bit", int'(v[1]), 1);
    if (mode == 2) begin
      check(ab_cnt == 4, "R9 abort frame length", ab_cnt, 4);
      check(ab_k == (wr != 0 ? 10 : 8) + nwait + tmo, "R9 abort timing", ab_k,
            (wr != 0 ? 10 : 8) + nwait + tmo);
    end
    for (int i = 0; i < exp_rx; i++) begin
      reg_read(8'h28, v);
      check(v[7:0] == rb(i), "R6 read queue order", int'(v[7:0]), int'(rb(i)));
    end
  endtask

  initial begin
    logic [31:0] v;
    int t;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(lframe_n == 1'b1, "R1 reset frame high", int'(lframe_n), 1);
    check(lad_oe == 1'b0, "R1 reset bus floated", int'(lad_oe), 0);
    check(irq == 1'b0, "R1 reset irq low", int'(irq), 0);
    check(cyc_phase == 4'd0, "R10 reset phase idle", int'(cyc_phase), 0);
    reg_read(8'h04, v);
    check(v == 32'h1, "R1 reset status", int'(v), 1);
    t = 0;
    for (int wr = 0; wr < 2; wr++)
      for (int same = 0; same < 2; same++)
        for (int len = 1; len <= 4; len++)
          for (int nw = 0; nw < 3; nw++) begin
            run_tr(t, wr, same, len, nw, 0, -1, 16'h02F8 + 16'(t * 263), 2'b00, 0, 16);
            t++;
          end
    run_tr(t++, 0, 0, 3, 1, 1, 1, 16'h0060, 2'b00, 0, 16);   // R8 read error
    run_tr(t++, 1, 0, 3, 0, 1, 2, 16'h0064, 2'b00, 0, 16);   // R8 write error
    run_tr(t++, 0, 1, 2, 2, 2, 0, 16'h03F8, 2'b00, 0, 5);    // R9 timeout after waits
    run_tr(t++, 1, 0, 2, 0, 2, 1, 16'h03F8, 2'b00, 0, 3);    // R9 timeout on second byte
    run_tr(t++, 0, 0, 2, 0, 0, -1, 16'h0080, 2'b01, 0, 16);  // R11 non-I/O type
    run_tr(t++, 1, 0, 0, 0, 0, -1, 16'h0080, 2'b00, 0, 16);  // R11 length zero
    run_tr(t++, 1, 0, 3, 1, 0, -1, 16'hFFFE, 2'b00, 1, 16);  // R11 busy start, R5 wrap
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule